// File: doc/BRIEF.md
# Serial Link Host Register Interface

This block is the register interface that a processor uses to reach a byte-wide serial link. The processor selects one of four byte registers with a 2-bit address and uses a read strobe or a write strobe. The four registers are received data, receive status, transmit data and transmit status.

The link side of the block is a set of handshake signals. A received byte arrives with a valid pulse. The far end's acknowledge arrives as a pulse, and so does the local transmitter's completion. The block asks the link to send an acknowledge packet or a data byte. It also drives one interrupt line for the receive direction and one for the transmit direction. Flow control is end to end:
- Consuming a received byte is what sends the acknowledge for it.
- A new byte may be written only after the previous byte has finished transmitting and has been acknowledged.

Each direction has its own state machine:
- **Receive machine.** It has two states, `RX_EMPTY` and `RX_FULL`.
  - `RX_EMPTY` → `RX_FULL` when a byte arrives.
  - `RX_FULL` → `RX_EMPTY` when the processor reads the data register and no new byte arrives in that cycle.
  - `RX_FULL` → `RX_FULL`, with the byte reloaded, when a new byte arrives.
- **Transmit machine.** It has four states: `TX_IDLE`, `TX_BUSY`, `TX_WAIT_ACK` and `TX_WAIT_DONE`. Only `TX_IDLE` means the transmitter is ready.
  - `TX_IDLE` → `TX_BUSY` on a write to the transmit data register.
  - `TX_BUSY` → `TX_IDLE` when completion and acknowledge arrive in the same cycle.
  - `TX_BUSY` → `TX_WAIT_ACK` on completion alone.
  - `TX_BUSY` → `TX_WAIT_DONE` on acknowledge alone.
  - `TX_WAIT_ACK` → `TX_IDLE` on acknowledge.
  - `TX_WAIT_DONE` → `TX_IDLE` on completion.

Top module: `link_host_regs`

## Requirements
- R1: After reset, the receive status reads 0x00 and the transmit status reads 0x01. Both interrupt lines are low. Neither `ack_req` nor `tx_req` pulses.
- R2: Register select values are: 0 = received data, 1 = receive status, 2 = transmit data, 3 = transmit status. In each status register:
  - bit 0 is the flag (data-present or ready);
  - bit 1 is the interrupt enable;
  - bits 7:2 read as 0.
  A status write changes only bit 1 and leaves the flag unchanged.
- R3: A cycle with `rx_valid` high stores `rx_byte` and sets data-present. Reads of select 0 then return that byte.
- R4: `in_irq` is high exactly when data-present is 1 and the receive enable is 1.
- R5: A read of select 0 while data-present is 1 clears data-present and `in_irq` at the next edge. It also raises `ack_req` for exactly one cycle, the cycle after the read.
- R6: A read of select 0 while data-present is 0 returns the last stored byte and produces no `ack_req`.
- R7: A write of select 2 while ready is 1 does three things at the next edge:
  - it clears ready and `out_irq`;
  - it raises `tx_req` for exactly one cycle;
  - it presents the written byte on `tx_byte`.
- R8: A write of select 2 while ready is 0 is ignored. It produces no `tx_req` and leaves `tx_byte` unchanged.
- R9: After a byte is launched, ready returns to 1 only once both `tx_done` and `ack_rcvd` have been seen. They may arrive in either order or in the same cycle.
- R10: `out_irq` is high exactly when ready is 1 and the transmit enable is 1.
- R11: A read of select 2 returns 0x00.
- R12: `tx_done` and `ack_rcvd` pulses that arrive while ready is 1 are ignored. They do not count toward the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register (combinational) |
| rx_valid | input | 1 | Received byte valid pulse |
| rx_byte | input | 8 | Received byte |
| ack_rcvd | input | 1 | Acknowledge received from the far end |
| tx_done | input | 1 | Local transmitter finished the current byte |
| ack_req | output | 1 | One-cycle request to send an acknowledge packet |
| tx_req | output | 1 | One-cycle request to send `tx_byte` |
| tx_byte | output | 8 | Byte to transmit |
| in_irq | output | 1 | Receive interrupt |
| out_irq | output | 1 | Transmit interrupt |

## Verification
The bench focuses on the ordering of completion and acknowledge:
- Completion first, acknowledge first, and both in the same cycle are all exercised. A design that re-armed on only one of the two would raise ready too early.
- Stray pulses arrive while idle, followed by a new write. A design that latched those pulses would finish the next byte early.

The bench also repeats a read of an empty receive buffer. A design that acknowledged every read would emit spurious acknowledge packets and break the far end's flow control. Writes while busy and writes to status registers are checked as well: a wrong design would relaunch a byte or corrupt a flag.

// File: rtl/link_host_pkg.sv
package link_host_pkg;
    typedef enum logic [1:0] {
        SEL_RX_DATA = 2'd0,
        SEL_RX_STAT = 2'd1,
        SEL_TX_DATA = 2'd2,
        SEL_TX_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE      = 2'd0,
        TX_BUSY      = 2'd1,
        TX_WAIT_ACK  = 2'd2,
        TX_WAIT_DONE = 2'd3
    } tx_state_e;

    localparam int FLAG_POS = 0;
    localparam int IE_POS   = 1;
endpackage

// File: rtl/link_rx_side.sv
module link_rx_side
    import link_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              data_rd,
    input  logic              ie_wr,
    input  logic              ie_val,
    output logic [DATA_W-1:0] held_byte,
    output logic              present,
    output logic              ie,
    output logic              ack_req,
    output logic              in_irq
);
    rx_state_e state_q, state_d;
    logic      consume;

    assign consume = data_rd && (state_q == RX_FULL);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (rx_valid) state_d = RX_FULL;
            RX_FULL:  if (consume && !rx_valid) state_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_EMPTY;
            held_byte <= '0;
            ie        <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rx_valid) held_byte <= rx_byte;
            if (ie_wr)    ie        <= ie_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ack_req <= 1'b0;
        else        ack_req <= consume;
    end

    assign present = (state_q == RX_FULL);
    assign in_irq  = present && ie;

    // R4
    in_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !in_irq);

    // R5
    ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> (!present || $past(rx_valid)));

    // R6
    no_ack_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !present) |=> !ack_req);
endmodule

// File: rtl/link_tx_side.sv
module link_tx_side
    import link_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              ie_wr,
    input  logic              ie_val,
    input  logic              tx_done,
    input  logic              ack_rcvd,
    output logic              ready,
    output logic              ie,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    output logic              out_irq
);
    tx_state_e state_q, state_d;
    logic      launch;

    assign launch = data_wr && (state_q == TX_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:      if (launch) state_d = TX_BUSY;
            TX_BUSY: begin
                if (tx_done && ack_rcvd) state_d = TX_IDLE;
                else if (tx_done)        state_d = TX_WAIT_ACK;
                else if (ack_rcvd)       state_d = TX_WAIT_DONE;
            end
            TX_WAIT_ACK:  if (ack_rcvd) state_d = TX_IDLE;
            TX_WAIT_DONE: if (tx_done)  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            ie      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ie_wr) ie <= ie_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_req  <= 1'b0;
            tx_byte <= '0;
        end else begin
            tx_req <= launch;
            if (launch) tx_byte <= wr_byte;
        end
    end

    assign ready   = (state_q == TX_IDLE);
    assign out_irq = ready && ie;

    // R10
    out_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !out_irq);

    // R8
    single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R9
    rearm_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state_q != TX_BUSY) || $past(tx_done && ack_rcvd)));

    // R7
    launch_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !ready);
endmodule

// File: rtl/link_host_regs.sv
module link_host_regs
    import link_host_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              ack_rcvd,
    input  logic              tx_done,
    output logic              ack_req,
    output logic              tx_req,
    output logic [DATA_W-1:0] tx_byte,
    output logic              in_irq,
    output logic              out_irq
);
    localparam int PAD_W = DATA_W - 2;

    reg_sel_e          sel;
    logic [DATA_W-1:0] rx_hold;
    logic              rx_present, rx_ie, tx_ready, tx_ie;

    assign sel = reg_sel_e'(reg_sel);

    link_rx_side #(.DATA_W(DATA_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .data_rd   (rd_en && sel == SEL_RX_DATA),
        .ie_wr     (wr_en && sel == SEL_RX_STAT),
        .ie_val    (wr_data[IE_POS]),
        .held_byte (rx_hold),
        .present   (rx_present),
        .ie        (rx_ie),
        .ack_req   (ack_req),
        .in_irq    (in_irq)
    );

    link_tx_side #(.DATA_W(DATA_W)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_wr  (wr_en && sel == SEL_TX_DATA),
        .wr_byte  (wr_data),
        .ie_wr    (wr_en && sel == SEL_TX_STAT),
        .ie_val   (wr_data[IE_POS]),
        .tx_done  (tx_done),
        .ack_rcvd (ack_rcvd),
        .ready    (tx_ready),
        .ie       (tx_ie),
        .tx_req   (tx_req),
        .tx_byte  (tx_byte),
        .out_irq  (out_irq)
    );

    always_comb begin
        unique case (sel)
            SEL_RX_DATA: rd_data = rx_hold;
            SEL_RX_STAT: rd_data = {{PAD_W{1'b0}}, rx_ie, rx_present};
            SEL_TX_DATA: rd_data = '0;
            SEL_TX_STAT: rd_data = {{PAD_W{1'b0}}, tx_ie, tx_ready};
        endcase
    end

    // R2
    stat_write_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_RX_STAT && !rx_valid && !rd_en) |=> $stable(rx_present));

    // R11
    tx_data_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_TX_DATA) |-> (rd_data == '0));
endmodule

// File: tb/link_host_regs_tb.sv
module link_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] reg_sel;
    logic       rd_en, wr_en, rx_valid, ack_rcvd, tx_done;
    logic [7:0] wr_data, rx_byte;
    logic [7:0] rd_data, tx_byte;
    logic       ack_req, tx_req, in_irq, out_irq;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    bit       m_full, m_ie_in, m_ie_out, m_busy, m_done_seen, m_ack_seen;
    bit       m_ack_req, m_tx_req;
    bit [7:0] m_byte, m_tx_byte;

    always #5 clk = ~clk;

    link_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_rcvd(ack_rcvd), .tx_done(tx_done), .ack_req(ack_req), .tx_req(tx_req),
        .tx_byte(tx_byte), .in_irq(in_irq), .out_irq(out_irq)
    );

    function automatic bit [7:0] exp_rd(input bit [1:0] s);
        case (s)
            2'd0: return m_byte;
            2'd1: return {6'b0, m_ie_in, m_full};
            2'd2: return 8'h00;
            default: return {6'b0, m_ie_out, !m_busy};
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(tag,   "rd_data", rd_data, exp_rd(reg_sel));
        chk("R4",  "in_irq",  {7'b0, in_irq},  {7'b0, m_full & m_ie_in});
        chk("R10", "out_irq", {7'b0, out_irq}, {7'b0, !m_busy & m_ie_out});
        chk("R5",  "ack_req", {7'b0, ack_req}, {7'b0, m_ack_req});
        chk("R7",  "tx_req",  {7'b0, tx_req},  {7'b0, m_tx_req});
        chk("R8",  "tx_byte", tx_byte, m_tx_byte);
    endtask

    // one clock: drive at negedge, check read before edge, model update, check after
    task automatic step(input bit [1:0] s, input bit rd, input bit wr, input bit [7:0] wd,
                        input bit rxv, input bit [7:0] rxb, input bit ackr, input bit done,
                        input string tag);
        bit n_full, n_busy, n_ds, n_as;
        reg_sel = s; rd_en = rd; wr_en = wr; wr_data = wd;
        rx_valid = rxv; rx_byte = rxb; ack_rcvd = ackr; tx_done = done;
        #1;
        if (rd) chk(tag, "read value", rd_data, exp_rd(s));
        m_ack_req = rd && s == 2'd0 && m_full;
        n_full = rxv ? 1'b1 : ((rd && s == 2'd0) ? 1'b0 : m_full);
        if (rxv) m_byte = rxb;
        if (wr && s == 2'd1) m_ie_in = wd[1];
        if (wr && s == 2'd3) m_ie_out = wd[1];
        m_full = n_full;
        m_tx_req = 1'b0;
        n_busy = m_busy; n_ds = m_done_seen; n_as = m_ack_seen;
        if (!m_busy) begin
            if (wr && s == 2'd2) begin
                n_busy = 1'b1; n_ds = 1'b0; n_as = 1'b0;
                m_tx_req = 1'b1; m_tx_byte = wd;
            end
        end else begin
            n_ds = n_ds | done;
            n_as = n_as | ackr;
            if (n_ds && n_as) n_busy = 1'b0;
        end
        m_busy = n_busy; m_done_seen = n_ds; m_ack_seen = n_as;
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle(input bit [1:0] s, input string tag);
        step(s, 0, 0, 8'h00, 0, 8'h00, 0, 0, tag);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_sel = 0; rd_en = 0; wr_en = 0; wr_data = 0;
        rx_valid = 0; rx_byte = 0; ack_rcvd = 0; tx_done = 0;
        m_full = 0; m_ie_in = 0; m_ie_out = 0; m_busy = 0; m_done_seen = 0; m_ack_seen = 0;
        m_ack_req = 0; m_tx_req = 0; m_byte = 0; m_tx_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values of both status registers
        step(2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R1");
        step(2'd3, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R1");
        // R2: status writes touch only the enable bit
        step(2'd1, 0, 1, 8'hFF, 0, 8'h00, 0, 0, "R2");
        step(2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
        step(2'd3, 0, 1, 8'hFE, 0, 8'h00, 0, 0, "R2");
        step(2'd3, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R10");
        // R3/R4: byte arrives, interrupt with enable set
        step(2'd0, 0, 0, 8'h00, 1, 8'hA5, 0, 0, "R3");
        step(2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R4");
        // R5: consuming read acknowledges once
        step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R5");
        // R6: read of empty buffer returns last byte, no ack
        step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R6");
        step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R6");
        // R4: enable cleared, byte present, no interrupt
        step(2'd1, 0, 1, 8'h00, 0, 8'h00, 0, 0, "R4");
        step(2'd1, 0, 0, 8'h00, 1, 8'h3C, 0, 0, "R4");
        step(2'd1, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R2");
        step(2'd0, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R5");
        idle(2'd0, "R5");
        // R7: launch, R11: data readback zero
        step(2'd2, 0, 1, 8'h5A, 0, 8'h00, 0, 0, "R7");
        step(2'd2, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R11");
        // R8: write while busy ignored
        step(2'd2, 0, 1, 8'h77, 0, 8'h00, 0, 0, "R8");
        idle(2'd3, "R8");
        // R9: completion then acknowledge
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R9");
        idle(2'd3, "R9");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R9");
        idle(2'd3, "R10");
        // R9: acknowledge then completion
        step(2'd2, 0, 1, 8'h11, 0, 8'h00, 0, 0, "R7");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R9");
        idle(2'd3, "R9");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R9");
        // R9: both in the same cycle
        step(2'd2, 0, 1, 8'h22, 0, 8'h00, 0, 0, "R7");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 1, 1, "R9");
        idle(2'd3, "R9");
        // R12: stray pulses while idle do not count
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R12");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R12");
        step(2'd2, 0, 1, 8'h33, 0, 8'h00, 0, 0, "R12");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 0, 1, "R12");
        idle(2'd3, "R12");
        step(2'd3, 0, 0, 8'h00, 0, 8'h00, 1, 0, "R9");
        // R10: transmit enable cleared
        step(2'd3, 0, 1, 8'h01, 0, 8'h00, 0, 0, "R10");
        step(2'd3, 1, 0, 8'h00, 0, 8'h00, 0, 0, "R10");
        idle(2'd0, "R3");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule